// File: doc/BRIEF.md
# Machine Trap State Capture Unit

This block keeps the machine-level trap state of a processor core in four registers: a scratch word, the exception program counter, the trap cause and the trap value. Software reaches them through a simple control-register port that has an address, a read strobe, a write strobe and a combinational read path. The trap logic of the core loads them through a single-cycle trap-entry port. That port carries the cause, the program counter of the faulting instruction, the faulting effective address, and the raw instruction bits with their length in 16-bit parcels.

The core of the block is the choice of what goes into the trap value register. Address-class faults store the faulting effective address. This covers misaligned, access and page faults on fetch, load and store, and breakpoints. An illegal-instruction trap stores the instruction bits: zero-extended when the instruction is shorter than the register, cut to the low-order word when it is longer, or plain zero when the capture option is built out. Every other exception and every interrupt leaves the register unchanged.

Because the upstream logic drives the address input, a fetch fault on a variable-length instruction can report the address of the faulting parcel while the program counter points at the start of the instruction. With translation active, the address is the virtual one. The interrupt-pending word at the fifth address is an input and is readable only.

Top module: `trapcap_regs`

## Requirements
- R1: After reset, the scratch, exception PC, cause and trap value registers all read as zero.
- R2: The addresses are base+0 (0x340) for scratch, 0x341 for exception PC, 0x342 for cause and 0x343 for trap value. A write with csr_wr_en loads the full word on the next clock edge, and a read with csr_rd_en returns the stored value in the same cycle.
- R3: Bit 0 of the exception PC is stored as zero on every load, whether the load comes from the control port or from trap entry.
- R4: On trap entry, the exception PC takes trap_pc. The cause register takes trap_irq in its most significant bit and trap_code in its low CODE_W bits, with all other bits zero.
- R5: When trap_irq is low and trap_code is 0, 1, 3, 4, 5, 6, 7, 12, 13 or 15, trap entry loads trap_addr into the trap value register.
- R6: When trap_irq is low and trap_code is 2 (illegal instruction) with capture enabled, the trap value register takes the low trap_plen×16 bits of trap_insn. All higher bits are zero.
- R7: If the instruction length is DATA_W bits or more, the trap value register holds the low DATA_W bits of trap_insn.
- R8: With CAPTURE_INSN = 0, an illegal-instruction trap writes zero into the trap value register.
- R9: Trap entry with any other code, and any trap with trap_irq high, leaves the trap value register unchanged.
- R10: In a cycle with trap_valid high, a control-port write is discarded entirely, including a write to the scratch register.
- R11: A read of 0x344 returns pend_bits. A write to 0x344 changes no register.
- R12: A read or write at 0x345–0x34F raises csr_illegal and reads zero. An address outside 0x340–0x34F reads zero with csr_illegal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | ADDR_W | Control-register address |
| csr_rd_en | input | 1 | Read strobe |
| csr_wr_en | input | 1 | Write strobe |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data, combinational |
| csr_illegal | output | 1 | Access to an unimplemented address in the block's range |
| pend_bits | input | DATA_W | Interrupt-pending word shown at 0x344 |
| trap_valid | input | 1 | Trap entry this cycle |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_pc | input | DATA_W | PC of the trapping instruction |
| trap_addr | input | DATA_W | Faulting effective address |
| trap_insn | input | INSN_W | Raw instruction bits, first parcel in the low bits |
| trap_plen | input | PLEN_W | Instruction length in 16-bit parcels |

## Verification
A wrong value in any register cannot stay hidden, because each one is exposed by a single read of its address in the cycle after it is loaded. A bad selection rule shows up as a stale or foreign word in the trap value register on the read after the trap. A wrong priority shows up as the written word in place of trap_pc. Both are checked on the read that follows each event. A build without capture is checked on a second instance that sees the same stimulus.

// File: rtl/trapcap_pkg.sv
`timescale 1ns/1ps
package trapcap_pkg;

    // register selected by an address offset inside the block's window
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SCRATCH,
        SEL_EPC,
        SEL_CAUSE,
        SEL_TVAL,
        SEL_PEND
    } csr_sel_e;

    localparam int PARCEL_W = 16;

    localparam int CC_FETCH_MISAL = 0;
    localparam int CC_FETCH_ACC   = 1;
    localparam int CC_ILLEGAL     = 2;
    localparam int CC_BKPT        = 3;
    localparam int CC_LOAD_MISAL  = 4;
    localparam int CC_LOAD_ACC    = 5;
    localparam int CC_STORE_MISAL = 6;
    localparam int CC_STORE_ACC   = 7;
    localparam int CC_FETCH_PF    = 12;
    localparam int CC_LOAD_PF     = 13;
    localparam int CC_STORE_PF    = 15;

    // exception codes whose trap value is the faulting address
    function automatic logic code_is_addr(input int code);
        case (code)
            CC_FETCH_MISAL, CC_FETCH_ACC, CC_BKPT,
            CC_LOAD_MISAL, CC_LOAD_ACC, CC_STORE_MISAL, CC_STORE_ACC,
            CC_FETCH_PF, CC_LOAD_PF, CC_STORE_PF: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trapcap_dec.sv
`timescale 1ns/1ps
module trapcap_dec
    import trapcap_pkg::*;
#(
    parameter int              ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE = 12'h340,
    parameter int              SPAN   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output csr_sel_e          sel,
    output logic              in_range
);
    localparam int OFF_W = $clog2(SPAN);

    logic [OFF_W-1:0] offset;

    always_comb begin
        in_range = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
        offset   = addr[OFF_W-1:0];
        sel      = SEL_NONE;
        if (in_range) begin
            case (int'(offset))
                0:       sel = SEL_SCRATCH;
                1:       sel = SEL_EPC;
                2:       sel = SEL_CAUSE;
                3:       sel = SEL_TVAL;
                4:       sel = SEL_PEND;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/trapcap_tval_sel.sv
`timescale 1ns/1ps
module trapcap_tval_sel
    import trapcap_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int INSN_W       = 64,
    parameter int CODE_W       = 4,
    parameter int PLEN_W       = 3,
    parameter bit CAPTURE_INSN = 1'b1
) (
    input  logic              trap_valid,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [DATA_W-1:0] trap_addr,
    input  logic [INSN_W-1:0] trap_insn,
    input  logic [PLEN_W-1:0] trap_plen,
    output logic              load,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] insn_lo;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] insn_kept;
    logic              is_addr;
    logic              is_illegal;

    // fit the raw instruction bits to the register width
    generate
        if (INSN_W >= DATA_W) begin : g_trunc
            assign insn_lo = trap_insn[DATA_W-1:0];
        end else begin : g_zext
            assign insn_lo = {{(DATA_W-INSN_W){1'b0}}, trap_insn};
        end
    endgenerate

    // bits above the instruction's own length are cleared
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            keep_mask[i] = (i < int'(trap_plen) * PARCEL_W);
        end
        insn_kept = insn_lo & keep_mask;
    end

    always_comb begin
        is_addr    = !trap_irq && code_is_addr(int'(trap_code));
        is_illegal = !trap_irq && (int'(trap_code) == CC_ILLEGAL);
        load       = trap_valid && (is_addr || is_illegal);
    end

    generate
        if (CAPTURE_INSN) begin : g_cap
            assign value = is_addr ? trap_addr : insn_kept;
        end else begin : g_nocap
            assign value = is_addr ? trap_addr : '0;
        end
    endgenerate
endmodule

// File: rtl/trapcap_regs.sv
`timescale 1ns/1ps
module trapcap_regs
    import trapcap_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 12,
    parameter int INSN_W       = 64,
    parameter int CODE_W       = 4,
    parameter int PLEN_W       = 3,
    parameter bit CAPTURE_INSN = 1'b1,
    parameter logic [ADDR_W-1:0] BASE = 12'h340
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd_en,
    input  logic              csr_wr_en,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic              csr_illegal,
    input  logic [DATA_W-1:0] pend_bits,
    input  logic              trap_valid,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [DATA_W-1:0] trap_pc,
    input  logic [DATA_W-1:0] trap_addr,
    input  logic [INSN_W-1:0] trap_insn,
    input  logic [PLEN_W-1:0] trap_plen
);
    localparam int SPAN = 16;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [DATA_W-1:0] epc;
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] tval;
    } state_t;

    state_t            st_d, st_q;
    csr_sel_e          sel;
    logic              in_range;
    logic              tval_load;
    logic [DATA_W-1:0] tval_value;
    logic [DATA_W-1:0] cause_word;

    trapcap_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .SPAN(SPAN)) u_dec (
        .addr     (csr_addr),
        .sel      (sel),
        .in_range (in_range)
    );

    trapcap_tval_sel #(
        .DATA_W(DATA_W), .INSN_W(INSN_W), .CODE_W(CODE_W),
        .PLEN_W(PLEN_W), .CAPTURE_INSN(CAPTURE_INSN)
    ) u_tval (
        .trap_valid (trap_valid),
        .trap_irq   (trap_irq),
        .trap_code  (trap_code),
        .trap_addr  (trap_addr),
        .trap_insn  (trap_insn),
        .trap_plen  (trap_plen),
        .load       (tval_load),
        .value      (tval_value)
    );

    // next-state: trap entry wins over any port write in the same cycle
    always_comb begin
        cause_word               = '0;
        cause_word[DATA_W-1]     = trap_irq;
        cause_word[CODE_W-1:0]   = trap_code;
        st_d = st_q;
        if (trap_valid) begin
            st_d.epc   = {trap_pc[DATA_W-1:1], 1'b0};
            st_d.cause = cause_word;
            if (tval_load) begin
                st_d.tval = tval_value;
            end
        end else if (csr_wr_en) begin
            case (sel)
                SEL_SCRATCH: st_d.scratch = csr_wdata;
                SEL_EPC:     st_d.epc     = {csr_wdata[DATA_W-1:1], 1'b0};
                SEL_CAUSE:   st_d.cause   = csr_wdata;
                SEL_TVAL:    st_d.tval    = csr_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read path
    always_comb begin
        csr_rdata   = '0;
        csr_illegal = (csr_rd_en || csr_wr_en) && in_range && (sel == SEL_NONE);
        if (csr_rd_en) begin
            case (sel)
                SEL_SCRATCH: csr_rdata = st_q.scratch;
                SEL_EPC:     csr_rdata = st_q.epc;
                SEL_CAUSE:   csr_rdata = st_q.cause;
                SEL_TVAL:    csr_rdata = st_q.tval;
                SEL_PEND:    csr_rdata = pend_bits;
                default:     csr_rdata = '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic addr_class;
    logic illegal_class;
    always_comb begin
        addr_class    = !trap_irq && (int'(trap_code) inside {0, 1, 3, 4, 5, 6, 7, 12, 13, 15});
        illegal_class = !trap_irq && (int'(trap_code) == 2);
    end

    a_r5_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && addr_class) |=> (st_q.tval == $past(trap_addr)));

    a_r9_tval_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !addr_class && !illegal_class) |=> $stable(st_q.tval));

    a_r8_nocap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!CAPTURE_INSN && trap_valid && illegal_class) |=> (st_q.tval == '0));

    a_r4_epc_load: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (st_q.epc == {$past(trap_pc[DATA_W-1:1]), 1'b0}));

    a_r4_cause_load: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> (st_q.cause[DATA_W-1] == $past(trap_irq)));

    a_r10_scratch_kept: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> $stable(st_q.scratch));

    a_r12_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));

    a_r3_epc_even: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.epc[0] == 1'b0);
endmodule

// File: tb/trapcap_regs_tb.sv
`timescale 1ns/1ps
module trapcap_regs_tb;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam int IW = 64;
    localparam int CW = 4;
    localparam int PW = 3;

    typedef struct {
        logic [DW-1:0] exp_cap;
        logic [DW-1:0] exp_nocap;
        logic          exp_ill;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic          csr_rd_en = 1'b0;
    logic          csr_wr_en = 1'b0;
    logic [DW-1:0] csr_wdata = '0;
    logic [DW-1:0] pend_bits = '0;
    logic          trap_valid = 1'b0;
    logic          trap_irq = 1'b0;
    logic [CW-1:0] trap_code = '0;
    logic [DW-1:0] trap_pc = '0;
    logic [DW-1:0] trap_addr = '0;
    logic [IW-1:0] trap_insn = '0;
    logic [PW-1:0] trap_plen = '0;
    logic [DW-1:0] rdata_a, rdata_b;
    logic          ill_a, ill_b;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #2.5 clk = ~clk;

    trapcap_regs #(.CAPTURE_INSN(1'b1)) u_dut (
        .clk, .rst_n, .csr_addr, .csr_rd_en, .csr_wr_en, .csr_wdata,
        .csr_rdata(rdata_a), .csr_illegal(ill_a), .pend_bits,
        .trap_valid, .trap_irq, .trap_code, .trap_pc, .trap_addr,
        .trap_insn, .trap_plen
    );

    trapcap_regs #(.CAPTURE_INSN(1'b0)) u_dut_nocap (
        .clk, .rst_n, .csr_addr, .csr_rd_en, .csr_wr_en, .csr_wdata,
        .csr_rdata(rdata_b), .csr_illegal(ill_b), .pend_bits,
        .trap_valid, .trap_irq, .trap_code, .trap_pc, .trap_addr,
        .trap_insn, .trap_plen
    );

    // monitor: compare each read against the queued expectation
    always begin
        @(negedge clk);
        #2;
        if (csr_rd_en) begin
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expectation queued");
            end else begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (rdata_a !== it.exp_cap || ill_a !== it.exp_ill) begin
                    errors++;
                    $display("FAIL %s: actual %h ill %b expected %h ill %b",
                             it.tag, rdata_a, ill_a, it.exp_cap, it.exp_ill);
                end
                checks++;
                if (rdata_b !== it.exp_nocap || ill_b !== it.exp_ill) begin
                    errors++;
                    $display("FAIL %s (no capture): actual %h ill %b expected %h ill %b",
                             it.tag, rdata_b, ill_b, it.exp_nocap, it.exp_ill);
                end
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] ea,
                      input logic [DW-1:0] eb, input logic eill, input string tag);
        item_t it;
        @(negedge clk);
        csr_addr  = a;
        csr_rd_en = 1'b1;
        it.exp_cap = ea; it.exp_nocap = eb; it.exp_ill = eill; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        csr_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        csr_addr  = a;
        csr_wdata = d;
        csr_wr_en = 1'b1;
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic trap(input logic irq, input logic [CW-1:0] code,
                        input logic [DW-1:0] pc, input logic [DW-1:0] ad,
                        input logic [IW-1:0] insn, input logic [PW-1:0] plen,
                        input logic with_wr, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd);
        @(negedge clk);
        trap_valid = 1'b1; trap_irq = irq; trap_code = code;
        trap_pc = pc; trap_addr = ad; trap_insn = insn; trap_plen = plen;
        csr_wr_en = with_wr; csr_addr = wa; csr_wdata = wd;
        @(negedge clk);
        trap_valid = 1'b0;
        csr_wr_en  = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(12'h340, 0, 0, 0, "R1 scratch reset");
        rd(12'h341, 0, 0, 0, "R1 epc reset");
        rd(12'h342, 0, 0, 0, "R1 cause reset");
        rd(12'h343, 0, 0, 0, "R1 tval reset");

        // R2 plain writes
        wr(12'h340, 32'hA5A5_0001);
        rd(12'h340, 32'hA5A5_0001, 32'hA5A5_0001, 0, "R2 scratch write");
        wr(12'h343, 32'h0000_1234);
        rd(12'h343, 32'h0000_1234, 32'h0000_1234, 0, "R2 tval write");
        wr(12'h342, 32'h0000_000A);
        rd(12'h342, 32'h0000_000A, 32'h0000_000A, 0, "R2 cause write");

        // R3 odd epc write
        wr(12'h341, 32'h0000_1003);
        rd(12'h341, 32'h0000_1002, 32'h0000_1002, 0, "R3 epc bit0 cleared");

        // R4/R5 load access fault
        trap(0, 4'd5, 32'h0000_8001, 32'hDEAD_BEE1, '0, 0, 0, 0, 0);
        rd(12'h341, 32'h0000_8000, 32'h0000_8000, 0, "R4 epc from trap, R3 even");
        rd(12'h342, 32'h0000_0005, 32'h0000_0005, 0, "R4 cause code");
        rd(12'h343, 32'hDEAD_BEE1, 32'hDEAD_BEE1, 0, "R5 load fault address");

        // R5 load page fault
        trap(0, 4'd13, 32'h0000_8100, 32'h4000_0002, '0, 0, 0, 0, 0);
        rd(12'h343, 32'h4000_0002, 32'h4000_0002, 0, "R5 page fault address");

        // R6/R8 short illegal instruction
        trap(0, 4'd2, 32'h0000_8200, 32'h1111_1111, 64'hFFFF_FFFF_FFFF_1234, 3'd1, 0, 0, 0);
        rd(12'h343, 32'h0000_1234, 32'h0000_0000, 0, "R6 zero-extend, R8 no capture");

        // R7/R8 long illegal instruction
        trap(0, 4'd2, 32'h0000_8280, 32'h2222_2222, 64'h1111_2222_3333_4444, 3'd4, 0, 0, 0);
        rd(12'h343, 32'h3333_4444, 32'h0000_0000, 0, "R7 truncate, R8 no capture");

        // R9 other exception
        trap(0, 4'd11, 32'h0000_8300, 32'h7777_7777, '1, 3'd2, 0, 0, 0);
        rd(12'h343, 32'h3333_4444, 32'h0000_0000, 0, "R9 tval held other code");
        rd(12'h342, 32'h0000_000B, 32'h0000_000B, 0, "R4 cause code 11");

        // R9 interrupt with an address-class code
        trap(1, 4'd7, 32'h0000_8400, 32'h6666_6666, '0, 0, 0, 0, 0);
        rd(12'h343, 32'h3333_4444, 32'h0000_0000, 0, "R9 tval held on interrupt");
        rd(12'h342, 32'h8000_0007, 32'h8000_0007, 0, "R4 interrupt flag in cause");
        rd(12'h341, 32'h0000_8400, 32'h0000_8400, 0, "R4 epc on interrupt");

        // R10 trap beats port write
        trap(0, 4'd8, 32'h0000_9001, 32'h0, '0, 0, 1, 12'h341, 32'h0000_5550);
        rd(12'h341, 32'h0000_9000, 32'h0000_9000, 0, "R10 epc from trap not write");
        trap(0, 4'd8, 32'h0000_9100, 32'h0, '0, 0, 1, 12'h340, 32'h0000_BEEF);
        rd(12'h340, 32'hA5A5_0001, 32'hA5A5_0001, 0, "R10 scratch write discarded");

        // R11 pending word
        pend_bits = 32'h0000_0888;
        rd(12'h344, 32'h0000_0888, 32'h0000_0888, 0, "R11 pending read");
        wr(12'h344, 32'hFFFF_FFFF);
        rd(12'h344, 32'h0000_0888, 32'h0000_0888, 0, "R11 pending write ignored");
        rd(12'h340, 32'hA5A5_0001, 32'hA5A5_0001, 0, "R11 scratch untouched");
        rd(12'h343, 32'h3333_4444, 32'h0000_0000, 0, "R11 tval untouched");

        // R12 unimplemented and foreign addresses
        rd(12'h345, 0, 0, 1, "R12 unimplemented 0x345");
        rd(12'h34F, 0, 0, 1, "R12 unimplemented 0x34F");
        rd(12'h300, 0, 0, 0, "R12 outside range");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule